// File: doc/BRIEF.md
# Custom-Instruction Execution Unit

This unit sits beside a soft processor's ALU and executes extended custom instructions. Each instruction carries an operation index, two 32-bit operands from the processor, three local register indices and three select flags. Each of the two sources, and the destination, can be switched on its own between the processor side and a small register file kept inside the unit. Source and destination choices can be mixed freely within one instruction.

Work is launched by a one-cycle `start` strobe and ends with a one-cycle `done` strobe. The cycle in which `done` is high also carries the valid `result`. While an operation is in flight, further strobes on `start` are dropped. Operation 0 is a fixed permutation: the two outer bytes trade places and the middle sixteen bits are mirrored. Operation 1 is a 32-bit addition with a longer, configurable latency. Every other index completes with a zero result.

Top module: `ci_exec_unit`

## Requirements
- R1: Operation index 0 returns a permutation of operand A: result bits 7..0 take A bits 31..24, result bits 31..24 take A bits 7..0, and result bit 8+k takes A bit 23-k for k = 0..15.
- R2: Operation index 1 returns (A + B) modulo 2^32.
- R3: Any operation index other than 0 and 1 returns zero and still completes with `done`, 2 cycles after its start cycle.
- R4: The start strobe is sampled at the clock edge that ends its cycle. Counting that cycle as cycle 0, operation 0 raises `done` in cycle 2 and operation 1 raises `done` in cycle ADD_LAT (default 4).
- R5: `done` is high for exactly one cycle per accepted instruction, and `result` holds the operation's value in that cycle.
- R6: A `start` strobe that arrives while an operation is in flight is ignored. It produces no extra `done` and does not alter the running operation's operands or result.
- R7: When `a_from_cpu` is 1, operand A is taken from `cpu_a`. When it is 0, operand A is read from the local register at `a_idx`. Operand B follows the same rule using `b_from_cpu`, `cpu_b` and `b_idx`.
- R8: When `res_to_cpu` is 0, the result is written into the local register at `c_idx` in the `done` cycle, and is also shown on `result`. When it is 1, the result is shown on `result` only, and the local register file is left unchanged.
- R9: A synchronous active-high `rst` clears every local register to zero, clears `done` and `result`, and abandons any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch strobe |
| op_sel | input | 8 | Operation index (0 permute, 1 add, others zero) |
| cpu_a | input | 32 | Operand A from the processor |
| cpu_b | input | 32 | Operand B from the processor |
| a_idx | input | 5 | Local register index for operand A |
| b_idx | input | 5 | Local register index for operand B |
| c_idx | input | 5 | Local register index for the destination |
| a_from_cpu | input | 1 | 1: A from `cpu_a`; 0: A from the local file |
| b_from_cpu | input | 1 | 1: B from `cpu_b`; 0: B from the local file |
| res_to_cpu | input | 1 | 1: result to the processor only; 0: also written to the local file |
| result | output | 32 | Operation result, valid while `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
The embedded assertions check several properties on every cycle. They confirm that `done` never lasts two cycles and that operation 0 always finishes exactly two cycles after it is accepted. They also confirm that latched operands stay still while an operation runs, that reset leaves the unit idle, and that every local write lands in the addressed register.

Other behaviour can only be shown by the bench's scenarios. These cover the arithmetic and permutation values and the zero result of unused indices. They also cover reads of values written by earlier instructions, the file staying intact when the result goes to the processor, the dropping of a strobe sent during a busy period, and a reset wiping a written register.

// File: rtl/ci_pkg.sv
package ci_pkg;
    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int OP_PERM  = 0;
    localparam int OP_ADD   = 1;
    localparam int BASE_LAT = 2;

    function automatic int unsigned op_cycles(input int unsigned op, input int unsigned add_lat);
        if (op == OP_ADD) return add_lat;
        return BASE_LAT;
    endfunction
endpackage

// File: rtl/ci_regfile.sv
module ci_regfile
    import ci_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [DATA_W-1:0] rd0_data,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_d [NREGS];
    logic [DATA_W-1:0] mem_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd0_data = mem_q[rd0_idx];
    assign rd1_data = mem_q[rd1_idx];

    // R8
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/ci_op_core.sv
module ci_op_core
    import ci_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    localparam int MID_W = DATA_W - 2 * BYTE_W;

    logic [DATA_W-1:0] perm;

    assign perm[BYTE_W-1:0]             = opa[DATA_W-1:DATA_W-BYTE_W];
    assign perm[DATA_W-1:DATA_W-BYTE_W] = opa[BYTE_W-1:0];

    for (genvar k = 0; k < MID_W; k++) begin : g_mirror
        assign perm[BYTE_W + k] = opa[DATA_W - BYTE_W - 1 - k];
    end

    always_comb begin
        if (int'(op) == OP_PERM)     res = perm;
        else if (int'(op) == OP_ADD) res = opa + opb;
        else                         res = '0;
    end
endmodule

// File: rtl/ci_exec_unit.sv
module ci_exec_unit
    import ci_pkg::*;
#(
    parameter int NREGS   = 32,
    parameter int NOPS    = 256,
    parameter int ADD_LAT = 4,
    localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int OP_W   = (NOPS > 1) ? $clog2(NOPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] cpu_a,
    input  logic [DATA_W-1:0] cpu_b,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [IDX_W-1:0]  c_idx,
    input  logic              a_from_cpu,
    input  logic              b_from_cpu,
    input  logic              res_to_cpu,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    localparam int ADD_CYC = (ADD_LAT < BASE_LAT) ? BASE_LAT : ADD_LAT;
    localparam int CNT_W   = $clog2(ADD_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [IDX_W-1:0]  dst;
        logic              to_cpu;
        logic [DATA_W-1:0] res;
    } ctl_t;

    ctl_t              st_d, st_q;
    logic [DATA_W-1:0] rf_a, rf_b, core_res;
    logic              wr_en;

    ci_regfile #(.NREGS(NREGS)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd0_idx  (a_idx),
        .rd1_idx  (b_idx),
        .rd0_data (rf_a),
        .rd1_data (rf_b),
        .wr_en    (wr_en),
        .wr_idx   (st_q.dst),
        .wr_data  (core_res)
    );

    ci_op_core #(.OP_W(OP_W)) u_core (
        .op  (st_q.op),
        .opa (st_q.a),
        .opb (st_q.b),
        .res (core_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wr_en     = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.op     = op_sel;
                st_d.a      = a_from_cpu ? cpu_a : rf_a;
                st_d.b      = b_from_cpu ? cpu_b : rf_b;
                st_d.dst    = c_idx;
                st_d.to_cpu = res_to_cpu;
                st_d.cnt    = CNT_W'(op_cycles(int'(op_sel), ADD_CYC) - 2);
            end
        end else if (st_q.cnt == '0) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = core_res;
            wr_en     = !st_q.to_cpu;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.res;
    assign done   = st_q.done;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    perm_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !st_q.busy && int'(op_sel) == OP_PERM) |=> ##1 done);

    // R6
    opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |=> (!st_q.busy || ($stable(st_q.op) && $stable(st_q.a) && $stable(st_q.b))));

    // R9
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!st_q.busy && !done && result == '0));
endmodule

// File: tb/ci_exec_unit_tb.sv
module ci_exec_unit_tb;
    localparam int ADD_LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  op_sel = '0;
    logic [31:0] cpu_a = '0, cpu_b = '0;
    logic [4:0]  a_idx = '0, b_idx = '0, c_idx = '0;
    logic        a_from_cpu = 1'b1, b_from_cpu = 1'b1, res_to_cpu = 1'b1;
    logic [31:0] result;
    logic        done;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ci_exec_unit #(.ADD_LAT(ADD_LAT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .cpu_a(cpu_a), .cpu_b(cpu_b), .a_idx(a_idx), .b_idx(b_idx), .c_idx(c_idx),
        .a_from_cpu(a_from_cpu), .b_from_cpu(b_from_cpu), .res_to_cpu(res_to_cpu),
        .result(result), .done(done)
    );

    function automatic logic [31:0] ref_perm(input logic [31:0] x);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) begin
            if (i < 8)        o[i] = x[24 + i];
            else if (i >= 24) o[i] = x[i - 24];
            else              o[i] = x[31 - i];
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] ia, input logic [4:0] ib, input logic [4:0] ic,
                         input logic ea, input logic eb, input logic ec,
                         output logic [31:0] res, output int lat);
        @(negedge clk);
        op_sel = op; cpu_a = a; cpu_b = b; a_idx = ia; b_idx = ib; c_idx = ic;
        a_from_cpu = ea; b_from_cpu = eb; res_to_cpu = ec; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        res = result;
        @(negedge clk);
        check(!done, "R5 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset_state();
        check(done == 1'b0, "R9 done after reset", 32'(done), 32'd0);
        check(result == '0, "R9 result after reset", result, 32'd0);
    endtask

    task automatic t_perm();
        logic [31:0] pats [4] = '{32'h12345678, 32'h80000001, 32'h00FF00FF, 32'hA5C3_0F1E};
        logic [31:0] r;
        int lat;
        foreach (pats[i]) begin
            issue(8'd0, pats[i], 32'hFFFF_FFFF, 0, 0, 0, 1, 1, 1, r, lat);
            check(r == ref_perm(pats[i]), "R1 permute value", r, ref_perm(pats[i]));
            check(lat == 2, "R4 permute latency", 32'(lat), 32'd2);
        end
    endtask

    task automatic t_add();
        logic [31:0] r;
        int lat;
        issue(8'd1, 32'd5, 32'd7, 0, 0, 0, 1, 1, 1, r, lat);
        check(r == 32'd12, "R2 add value", r, 32'd12);
        check(lat == ADD_LAT, "R4 add latency", 32'(lat), 32'(ADD_LAT));
        issue(8'd1, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, 1, 1, 1, r, lat);
        check(r == 32'd1, "R2 add wrap", r, 32'd1);
    endtask

    task automatic t_unused();
        logic [31:0] r;
        int lat;
        issue(8'd7, 32'h1234, 32'h5678, 0, 0, 0, 1, 1, 1, r, lat);
        check(r == '0 && lat == 2, "R3 op 7 zero", r, 32'd0);
        issue(8'd255, 32'hFFFF, 32'h1, 0, 0, 0, 1, 1, 1, r, lat);
        check(r == '0 && lat == 2, "R3 op 255 zero", r, 32'd0);
    endtask

    task automatic t_local_regs();
        logic [31:0] r;
        int lat;
        // write r3 = 0x100 + 0x23 (dest local)
        issue(8'd1, 32'h100, 32'h23, 0, 0, 5'd3, 1, 1, 0, r, lat);
        check(r == 32'h123, "R8 local write shown on result", r, 32'h123);
        // write r9 = 0x10
        issue(8'd1, 32'h10, 32'h0, 0, 0, 5'd9, 1, 1, 0, r, lat);
        // A local r3, B from cpu
        issue(8'd1, 32'hDEAD, 32'd1, 5'd3, 0, 0, 0, 1, 1, r, lat);
        check(r == 32'h124, "R7 A from local", r, 32'h124);
        // both local r3 + r9
        issue(8'd1, 32'hDEAD, 32'hBEEF, 5'd3, 5'd9, 0, 0, 0, 1, r, lat);
        check(r == 32'h133, "R7 A and B local", r, 32'h133);
        // B local only
        issue(8'd1, 32'd2, 32'hBEEF, 0, 5'd9, 0, 1, 0, 1, r, lat);
        check(r == 32'h12, "R7 B from local", r, 32'h12);
        // permute of local r3
        issue(8'd0, 32'h0, 32'h0, 5'd3, 0, 0, 0, 1, 1, r, lat);
        check(r == ref_perm(32'h123), "R1 R7 permute local", r, ref_perm(32'h123));
        // result to cpu with c=3 must not alter r3
        issue(8'd1, 32'h777, 32'h0, 0, 0, 5'd3, 1, 1, 1, r, lat);
        issue(8'd1, 32'h0, 32'h0, 5'd3, 0, 0, 0, 1, 1, r, lat);
        check(r == 32'h123, "R8 cpu dest leaves file", r, 32'h123);
    endtask

    task automatic t_busy_ignore();
        int ndone = 0;
        int first = 0;
        logic [31:0] r = '0;
        @(negedge clk);
        op_sel = 8'd1; cpu_a = 32'd1; cpu_b = 32'd2;
        a_from_cpu = 1; b_from_cpu = 1; res_to_cpu = 1; start = 1'b1;
        @(negedge clk);
        // cycle 1: second strobe with different operands while busy
        op_sel = 8'd0; cpu_a = 32'hCAFE_F00D; cpu_b = 32'd9;
        for (int n = 1; n <= 12; n++) begin
            if (done) begin
                ndone++;
                if (first == 0) begin first = n; r = result; end
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(ndone == 1, "R6 single done", 32'(ndone), 32'd1);
        check(r == 32'd3, "R6 result of first", r, 32'd3);
        check(first == ADD_LAT, "R6 latency of first", 32'(first), 32'(ADD_LAT));
    endtask

    task automatic t_reset_clears();
        logic [31:0] r;
        int lat;
        issue(8'd1, 32'h55, 32'h0, 0, 0, 5'd5, 1, 1, 0, r, lat);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(done == 1'b0 && result == '0, "R9 outputs cleared", result, 32'd0);
        issue(8'd1, 32'h0, 32'h0, 5'd5, 0, 0, 0, 1, 1, r, lat);
        check(r == '0, "R9 file cleared", r, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_perm();
        t_add();
        t_unused();
        t_local_regs();
        t_busy_ignore();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule